// File: doc/BRIEF.md
# Miscellaneous Immediate Instruction Decoder

This block classifies one 32-bit instruction word that belongs to the immediate miscellaneous group of a 32-bit instruction set. It lives in the decode stage of a processor front end. It does not evaluate condition codes, read registers or execute anything. It turns the word into a small set of decoded fields that later stages consume.

The opcode field selects the operation. One value is a move of a 16-bit constant into the low half of a register. Another is a move into the top half, which keeps the low half, so the destination register is also a source. A third value writes the current status register, but when its register-select field is zero the word becomes a hint instead (no-op, yield, wait for event, wait for interrupt or send event), chosen by the low immediate byte. A fourth value writes the saved status register. For every word the block also produces a rotated 32-bit immediate and a 4-bit field byte mask, which the status-register writes use.

An input strobe qualifies the word. A group-select input must also be high, or the word decodes as undefined. With the default configuration the decoded outputs are registered, so a valid output follows the strobe by one cycle. Between strobes the outputs hold their last decoded value.

Top module: `misc_imm_decoder`

## Requirements
- R1: When the opcode field insn[24:21] is 4'h8, op_class is 1 (move low). wide_imm is {insn[19:16], insn[11:0]}, and rd is insn[15:12].
- R2: When the opcode is 4'hA, op_class is 2 (move top) and wide_imm is assembled as in R1. rd_is_src is 1 only for op_class 2 and is 0 for every other class.
- R3: When the opcode is 4'h9 and insn[19:16] is zero, insn[7:0] selects a hint. The values 0, 1, 2, 3 and 4 give op_class 3 (no-op), 4 (yield), 5 (wait for event), 6 (wait for interrupt) and 7 (send event). Any other byte value gives op_class 0 (undefined).
- R4: When the opcode is 4'h9 and insn[19:16] is nonzero, op_class is 8 (current status write). When the opcode is 4'hB, op_class is 9 (saved status write), whatever insn[19:16] holds.
- R5: rot_imm is {24'b0, insn[7:0]} rotated right by 2*insn[11:8] bit positions. byte_mask is insn[19:16].
- R6: When insn[11:8] is zero, rot_imm equals insn[7:0] zero-extended to 32 bits.
- R7: Every opcode value outside 4'h8 to 4'hB gives op_class 0.
- R8: When grp_sel is low with a strobe, op_class is 0.
- R9: valid_out is valid_in delayed by exactly one clock cycle. The outputs decoded from a strobed word appear in that same cycle.
- R10: In a cycle after which valid_in was low, all decoded outputs keep their previous values.
- R11: While rst_n is low, and after release until the first strobe, valid_out is 0, op_class is 0 and all fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Qualifies insn for capture |
| grp_sel | input | 1 | Word belongs to the miscellaneous immediate group |
| insn | input | 32 | Instruction word |
| valid_out | output | 1 | Decoded outputs are fresh this cycle |
| op_class | output | 4 | Operation class code (values in R1 to R8) |
| rd | output | 4 | Destination register index |
| rd_is_src | output | 1 | Destination is also read (move top) |
| wide_imm | output | 16 | Assembled 16-bit move immediate |
| rot_imm | output | 32 | Rotated status-write immediate |
| byte_mask | output | 4 | Status-write field byte mask |

## Verification
On every cycle the assertions check the one-cycle valid latency and the holding of the outputs between strobes. They also check the forced undefined class when the group is not selected, the link between rd_is_src and the move-top class, and the nonzero mask of a current-status write. They further check that the rotation keeps the bit count of the source byte, that a zero rotation passes the byte through, and the move-low immediate assembly. The exact hint table, the rejection of out-of-range hint bytes and opcodes, and the exact rotated value for every amount are shown only by the bench's reference model. That model covers directed words for each case and a long run of biased random words.

// File: rtl/misc_dec_pkg.sv
package misc_dec_pkg;

   localparam int WORD_W   = 32;
   localparam int OPC_LSB  = 21;
   localparam int OPC_W    = 4;
   localparam int RN_LSB   = 16;
   localparam int RD_LSB   = 12;
   localparam int ROT_LSB  = 8;
   localparam int FIELD_W  = 4;
   localparam int IMM8_W   = 8;
   localparam int LOW12_W  = 12;
   localparam int WIDE_W   = FIELD_W + LOW12_W;

   localparam logic [OPC_W-1:0] OPC_MOVE_LOW = 4'h8;
   localparam logic [OPC_W-1:0] OPC_HINT_SR  = 4'h9;
   localparam logic [OPC_W-1:0] OPC_MOVE_TOP = 4'hA;
   localparam logic [OPC_W-1:0] OPC_SAVED_SR = 4'hB;

   typedef enum logic [3:0] {
      CLS_UNDEF       = 4'd0,
      CLS_MOVE_LOW    = 4'd1,
      CLS_MOVE_TOP    = 4'd2,
      CLS_NOP         = 4'd3,
      CLS_YIELD       = 4'd4,
      CLS_WAIT_EVT    = 4'd5,
      CLS_WAIT_IRQ    = 4'd6,
      CLS_SEND_EVT    = 4'd7,
      CLS_WR_CUR_SR   = 4'd8,
      CLS_WR_SAVED_SR = 4'd9
   } op_class_e;

   typedef struct packed {
      op_class_e           cls;
      logic [FIELD_W-1:0]  rd;
      logic                rd_src;
      logic [WIDE_W-1:0]   wide;
      logic [WORD_W-1:0]   rot;
      logic [FIELD_W-1:0]  mask;
   } dec_word_t;

endpackage

// File: rtl/misc_field_split.sv
module misc_field_split
   import misc_dec_pkg::*;
(
   input  logic [WORD_W-1:0]  insn,
   output logic [OPC_W-1:0]   opc,
   output logic [FIELD_W-1:0] rn,
   output logic [FIELD_W-1:0] rd,
   output logic [FIELD_W-1:0] rot_sel,
   output logic [IMM8_W-1:0]  imm8,
   output logic [WIDE_W-1:0]  wide
);

   logic unused_bits;

   assign opc     = insn[OPC_LSB +: OPC_W];
   assign rn      = insn[RN_LSB  +: FIELD_W];
   assign rd      = insn[RD_LSB  +: FIELD_W];
   assign rot_sel = insn[ROT_LSB +: FIELD_W];
   assign imm8    = insn[0 +: IMM8_W];
   assign wide    = {insn[RN_LSB +: FIELD_W], insn[0 +: LOW12_W]};

   assign unused_bits = ^{insn[WORD_W-1:OPC_LSB+OPC_W], insn[RN_LSB+FIELD_W +: OPC_LSB-RN_LSB-FIELD_W]};

endmodule

// File: rtl/misc_ror_imm.sv
module misc_ror_imm #(
   parameter int DATA_W = 32,
   parameter int SRC_W  = 8,
   parameter int SEL_W  = 4
) (
   input  logic [SRC_W-1:0]  src,
   input  logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] res
);

   localparam int AMT_W = $clog2(DATA_W);

   if (SEL_W + 1 != AMT_W) begin : g_bad_sel
      $error("misc_ror_imm: SEL_W+1 must equal log2(DATA_W)");
   end
   if (SRC_W > DATA_W) begin : g_bad_src
      $error("misc_ror_imm: SRC_W exceeds DATA_W");
   end

   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] stage [AMT_W+1];

   assign amt      = {sel, 1'b0};
   assign stage[0] = {{(DATA_W-SRC_W){1'b0}}, src};

   for (genvar i = 0; i < AMT_W; i++) begin : g_stage
      localparam int SH = 1 << i;
      assign stage[i+1] = amt[i] ? {stage[i][SH-1:0], stage[i][DATA_W-1:SH]} : stage[i];
   end

   assign res = stage[AMT_W];

endmodule

// File: rtl/misc_class_dec.sv
module misc_class_dec
   import misc_dec_pkg::*;
(
   input  logic               grp_sel,
   input  logic [OPC_W-1:0]   opc,
   input  logic [FIELD_W-1:0] rn,
   input  logic [IMM8_W-1:0]  imm8,
   output op_class_e          cls,
   output logic               rd_src
);

   op_class_e hint_cls;

   always_comb begin
      case (imm8)
         8'd0:    hint_cls = CLS_NOP;
         8'd1:    hint_cls = CLS_YIELD;
         8'd2:    hint_cls = CLS_WAIT_EVT;
         8'd3:    hint_cls = CLS_WAIT_IRQ;
         8'd4:    hint_cls = CLS_SEND_EVT;
         default: hint_cls = CLS_UNDEF;
      endcase
   end

   always_comb begin
      cls = CLS_UNDEF;
      if (grp_sel) begin
         case (opc)
            OPC_MOVE_LOW: cls = CLS_MOVE_LOW;
            OPC_MOVE_TOP: cls = CLS_MOVE_TOP;
            OPC_SAVED_SR: cls = CLS_WR_SAVED_SR;
            OPC_HINT_SR:  cls = (rn == '0) ? hint_cls : CLS_WR_CUR_SR;
            default:      cls = CLS_UNDEF;
         endcase
      end
   end

   assign rd_src = (cls == CLS_MOVE_TOP);

endmodule

// File: rtl/misc_out_stage.sv
module misc_out_stage
   import misc_dec_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      valid_in,
   input  dec_word_t d,
   output logic      valid_out,
   output dec_word_t q
);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_out <= 1'b0;
            q         <= '0;
         end else begin
            valid_out <= valid_in;
            if (valid_in) begin
               q <= d;
            end
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign valid_out  = valid_in;
      assign q          = d;
   end

endmodule

// File: rtl/misc_imm_decoder.sv
module misc_imm_decoder
   import misc_dec_pkg::*;
#(
   parameter int INSN_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic              grp_sel,
   input  logic [INSN_W-1:0] insn,
   output logic              valid_out,
   output logic [3:0]        op_class,
   output logic [3:0]        rd,
   output logic              rd_is_src,
   output logic [15:0]       wide_imm,
   output logic [31:0]       rot_imm,
   output logic [3:0]        byte_mask
);

   if (INSN_W != WORD_W) begin : g_bad_width
      $error("misc_imm_decoder: INSN_W must be 32");
   end

   logic [OPC_W-1:0]   f_opc;
   logic [FIELD_W-1:0] f_rn;
   logic [FIELD_W-1:0] f_rd;
   logic [FIELD_W-1:0] f_rot;
   logic [IMM8_W-1:0]  f_imm8;
   logic [WIDE_W-1:0]  f_wide;
   logic [WORD_W-1:0]  f_rotated;
   op_class_e          f_cls;
   logic               f_rd_src;
   dec_word_t          dec_d;
   dec_word_t          dec_q;

   misc_field_split u_split (
      .insn    (insn),
      .opc     (f_opc),
      .rn      (f_rn),
      .rd      (f_rd),
      .rot_sel (f_rot),
      .imm8    (f_imm8),
      .wide    (f_wide)
   );

   misc_ror_imm #(
      .DATA_W (WORD_W),
      .SRC_W  (IMM8_W),
      .SEL_W  (FIELD_W)
   ) u_ror (
      .src (f_imm8),
      .sel (f_rot),
      .res (f_rotated)
   );

   misc_class_dec u_cls (
      .grp_sel (grp_sel),
      .opc     (f_opc),
      .rn      (f_rn),
      .imm8    (f_imm8),
      .cls     (f_cls),
      .rd_src  (f_rd_src)
   );

   always_comb begin
      dec_d.cls    = f_cls;
      dec_d.rd     = f_rd;
      dec_d.rd_src = f_rd_src;
      dec_d.wide   = f_wide;
      dec_d.rot    = f_rotated;
      dec_d.mask   = f_rn;
   end

   misc_out_stage #(
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_in  (valid_in),
      .d         (dec_d),
      .valid_out (valid_out),
      .q         (dec_q)
   );

   assign op_class  = dec_q.cls;
   assign rd        = dec_q.rd;
   assign rd_is_src = dec_q.rd_src;
   assign wide_imm  = dec_q.wide;
   assign rot_imm   = dec_q.rot;
   assign byte_mask = dec_q.mask;

endmodule

// File: rtl/misc_imm_decoder_chk.sv
module misc_imm_decoder_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        valid_in,
   input logic        grp_sel,
   input logic [31:0] insn,
   input logic        valid_out,
   input logic [3:0]  op_class,
   input logic        rd_is_src,
   input logic [15:0] wide_imm,
   input logic [31:0] rot_imm,
   input logic [3:0]  byte_mask
);

   p_src_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out |-> (rd_is_src == (op_class == 4'd2)));

   p_class_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_class <= 4'd9);

   p_cur_sr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && op_class == 4'd8) |-> (byte_mask != 4'd0));

   if (OUT_REG) begin : g_seq
      p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> valid_out);

      p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> !valid_out);

      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> ($stable(op_class) && $stable(wide_imm) && $stable(rot_imm) && $stable(byte_mask)));

      p_grp_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && !grp_sel) |=> (op_class == 4'd0));

      p_rot_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> ($countones(rot_imm) == $countones($past(insn[7:0]))));

      p_zero_rot_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && insn[11:8] == 4'd0) |=> (rot_imm == {24'd0, $past(insn[7:0])}));

      p_move_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && grp_sel && insn[24:21] == 4'h8) |=>
            (op_class == 4'd1 && wide_imm == {$past(insn[19:16]), $past(insn[11:0])}));
   end

endmodule

bind misc_imm_decoder misc_imm_decoder_chk #(
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .grp_sel   (grp_sel),
   .insn      (insn),
   .valid_out (valid_out),
   .op_class  (op_class),
   .rd_is_src (rd_is_src),
   .wide_imm  (wide_imm),
   .rot_imm   (rot_imm),
   .byte_mask (byte_mask)
);

// File: tb/tb_misc_imm_decoder.sv
module tb_misc_imm_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic        grp_sel = 1'b0;
   logic [31:0] insn = '0;
   logic        valid_out;
   logic [3:0]  op_class;
   logic [3:0]  rd;
   logic        rd_is_src;
   logic [15:0] wide_imm;
   logic [31:0] rot_imm;
   logic [3:0]  byte_mask;

   int checks = 0;
   int fails  = 0;

   // reference expectation for the next sampled cycle
   int          e_cls = 0;
   logic [3:0]  e_rd = '0;
   logic        e_src = 1'b0;
   logic [15:0] e_wide = '0;
   logic [31:0] e_rot = '0;
   logic [3:0]  e_mask = '0;
   logic [3:0]  e_rsel = '0;
   logic        e_valid = 1'b0;
   logic        last_v = 1'b0;

   always #4 clk = ~clk;

   misc_imm_decoder dut (
      .clk (clk), .rst_n (rst_n), .valid_in (valid_in), .grp_sel (grp_sel),
      .insn (insn), .valid_out (valid_out), .op_class (op_class), .rd (rd),
      .rd_is_src (rd_is_src), .wide_imm (wide_imm), .rot_imm (rot_imm),
      .byte_mask (byte_mask)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int ref_class(input logic g, input logic [31:0] w);
      int opc = int'(w[24:21]);
      int sub = int'(w[7:0]);
      if (!g) return 0;
      if (opc == 8)  return 1;
      if (opc == 10) return 2;
      if (opc == 11) return 9;
      if (opc == 9) begin
         if (w[19:16] != 0) return 8;
         if (sub <= 4) return 3 + sub;
         return 0;
      end
      return 0;
   endfunction

   function automatic logic [31:0] ref_rot(input logic [31:0] w);
      logic [31:0] v = {24'd0, w[7:0]};
      int n = 2 * int'(w[11:8]);
      logic [31:0] r = v;
      for (int k = 0; k < n; k++) r = {r[0], r[31:1]};
      return r;
   endfunction

   function automatic string class_tag(input int c, input logic [31:0] w, input logic g);
      if (!g) return "R8";
      if (c == 1) return "R1";
      if (c == 2) return "R2";
      if (c >= 3 && c <= 7) return "R3";
      if (c == 8 || c == 9) return "R4";
      if (w[24:21] == 4'h9) return "R3";
      return "R7";
   endfunction

   string cur_tag = "R11";

   task automatic compare();
      string t;
      chk("R9", "valid_out", 32'(valid_out), 32'(e_valid));
      t = last_v ? cur_tag : "R10";
      chk(t, "op_class", 32'(op_class), 32'(e_cls));
      chk(last_v ? "R1" : "R10", "rd", 32'(rd), 32'(e_rd));
      chk(last_v ? "R2" : "R10", "rd_is_src", 32'(rd_is_src), 32'(e_src));
      chk(last_v ? "R1" : "R10", "wide_imm", 32'(wide_imm), 32'(e_wide));
      chk(last_v ? ((e_rsel == 0) ? "R6" : "R5") : "R10", "rot_imm", rot_imm, e_rot);
      chk(last_v ? "R5" : "R10", "byte_mask", 32'(byte_mask), 32'(e_mask));
   endtask

   task automatic step(input logic v, input logic g, input logic [31:0] w);
      @(negedge clk);
      compare();
      valid_in = v;
      grp_sel  = g;
      insn     = w;
      e_valid  = v;
      last_v   = v;
      if (v) begin
         e_cls   = ref_class(g, w);
         e_rd    = w[15:12];
         e_src   = (e_cls == 2);
         e_wide  = {w[19:16], w[11:0]};
         e_rot   = ref_rot(w);
         e_mask  = w[19:16];
         e_rsel  = w[11:8];
         cur_tag = class_tag(e_cls, w, g);
      end
   endtask

   function automatic logic [31:0] mk(input logic [3:0] opc, input logic [3:0] rn, input logic [3:0] rdi,
                                      input logic [3:0] rot, input logic [7:0] b);
      return {7'h0, opc, 1'b0, rn, rdi, rot, b};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      // R11 reset state
      repeat (3) @(negedge clk);
      chk("R11", "valid_out", 32'(valid_out), 0);
      chk("R11", "op_class", 32'(op_class), 0);
      chk("R11", "rot_imm", rot_imm, 0);
      chk("R11", "wide_imm", 32'(wide_imm), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "valid_out", 32'(valid_out), 0);
      chk("R11", "byte_mask", 32'(byte_mask), 0);

      // R1 / R2 wide moves
      step(1, 1, mk(4'h8, 4'hA, 4'h3, 4'h5, 8'hC7));
      step(1, 1, mk(4'hA, 4'h5, 4'hE, 4'h0, 8'h12));
      step(1, 1, mk(4'h8, 4'hF, 4'h0, 4'hF, 8'hFF));
      // R3 hints, including out-of-range bytes
      for (int h = 0; h < 8; h++) step(1, 1, mk(4'h9, 4'h0, 4'h1, 4'h0, 8'(h)));
      step(1, 1, mk(4'h9, 4'h0, 4'h1, 4'h0, 8'hFF));
      step(1, 1, mk(4'h9, 4'h0, 4'h1, 4'h2, 8'h01));
      // R4 / R5 / R6 status writes with several rotations
      step(1, 1, mk(4'h9, 4'h1, 4'h0, 4'h0, 8'hA5));
      step(1, 1, mk(4'h9, 4'h9, 4'h0, 4'h1, 8'h81));
      step(1, 1, mk(4'h9, 4'hF, 4'h0, 4'hF, 8'hC3));
      step(1, 1, mk(4'hB, 4'h0, 4'h0, 4'h4, 8'h3C));
      step(1, 1, mk(4'hB, 4'h6, 4'h0, 4'h8, 8'hFF));
      // R7 every opcode outside the group range
      for (int o = 0; o < 16; o++) step(1, 1, mk(4'(o), 4'h2, 4'h7, 4'h3, 8'h04));
      // R8 group not selected
      step(1, 0, mk(4'h8, 4'h2, 4'h2, 4'h0, 8'h11));
      step(1, 0, mk(4'h9, 4'h0, 4'h2, 4'h0, 8'h02));
      // R10 holding across idle cycles with changing words
      step(1, 1, mk(4'hA, 4'h3, 4'h9, 4'h2, 8'h44));
      step(0, 1, mk(4'h8, 4'h1, 4'h1, 4'h1, 8'h01));
      step(0, 0, 32'hFFFF_FFFF);
      step(0, 1, mk(4'hB, 4'h7, 4'h2, 4'h6, 8'h99));
      step(1, 1, mk(4'h9, 4'h0, 4'h4, 4'h0, 8'h04));
      // biased random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] w = $urandom;
         int pick = int'($urandom_range(0, 9));
         if (pick < 6) w[24:21] = 4'h8 + 4'(pick % 4);
         if (pick == 1 || pick == 5) w[19:16] = 4'h0;
         if (pick == 5) w[7:0] = 8'($urandom_range(0, 6));
         step(($urandom_range(0, 3) != 0), ($urandom_range(0, 7) != 0), w);
      end
      step(0, 0, '0);
      step(0, 0, '0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule